// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits behind a receive byte stream and decides whether an arriving frame is addressed to this station. It takes the six destination address bytes, in wire order, over a valid/ready byte interface. While the bytes arrive it folds them into a reflected CRC-32, one byte per beat. It then reduces the final CRC to a 6-bit hash index and looks that index up in a 64-bit hash table. The same address is also compared with a programmed station address, and an all-ones broadcast address is recognised.

Two hash tables are held, and each is split into a lower and an upper 32-bit word. The individual table serves addresses whose first byte has bit 0 clear. The group table serves addresses whose first byte has bit 0 set. The verdict comes out as a one-cycle result pulse with an accept flag, in the cycle after the sixth byte is taken. A frame-start strobe re-arms the block for the next frame.

Back-pressure: `in_ready` is held high from the first cycle after reset release, and the block never stalls the stream. A byte is taken on any edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low are bubbles and change nothing.

Top module: `addr_filter`

## Requirements
- R1: At reset and at every frame start the CRC register is preset to 0xFFFFFFFF. Each taken byte is folded in least significant bit first. For each bit, the register shifts right by one, and 0xEDB88320 is XORed in when the data bit differs from the register's bit 0. Exactly six bytes are folded per frame.
- R2: The hash index is bits [31:26] of the CRC after the sixth byte. Index values 32..63 select bit (index-32) of the upper table word. Index values 0..31 select bit index of the lower table word.
- R3: Bit 0 of the first destination byte selects the table: 0 selects the individual pair (`ind_tbl_hi`/`ind_tbl_lo`), 1 selects the group pair (`grp_tbl_hi`/`grp_tbl_lo`). A bit set only in the other pair does not accept the frame.
- R4: `exact_hi` holds bytes 0..3, with byte 0 in bits [31:24] and byte 3 in bits [7:0]. `exact_lo` holds byte 4 in bits [15:8] and byte 5 in bits [7:0]. An address equal to this pair is accepted whatever the tables hold.
- R5: The all-ones address is accepted when `bcast_reject` is low. When `bcast_reject` is high, only the exact match or the hash table can accept it.
- R6: `result_valid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte. `accept` is low whenever `result_valid` is low.
- R7: Bytes taken after the sixth one and before the next frame start are ignored and produce no further result.
- R8: A `frame_start` pulse discards a partly received address. A byte taken in the same cycle as `frame_start` is the first byte of the new frame.
- R9: `in_ready` is high from the first cycle after reset release. Bubble cycles (`in_valid` low) do not advance the byte count and do not change the verdict.
- R10: During reset `result_valid` and `accept` are low. After reset the block is armed as if a frame start had occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe that re-arms the block for a new frame |
| in_valid | input | 1 | Address byte is valid |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Destination address byte, wire order |
| exact_hi | input | 32 | Station address bytes 0..3, byte 0 in the top bits |
| exact_lo | input | 16 | Station address bytes 4..5, byte 4 in the top bits |
| ind_tbl_hi | input | 32 | Individual hash table, indices 32..63 |
| ind_tbl_lo | input | 32 | Individual hash table, indices 0..31 |
| grp_tbl_hi | input | 32 | Group hash table, indices 32..63 |
| grp_tbl_lo | input | 32 | Group hash table, indices 0..31 |
| bcast_reject | input | 1 | Refuse the all-ones address unless another rule accepts it |
| result_valid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame accepted, qualified by result_valid |

## Verification
The hash path is exercised with unicast and multicast addresses under four table setups:
- Tables all clear.
- Only the predicted bit set in the correct pair. This separates a wrong CRC or index from a correct one.
- Every bit set except the predicted one. This catches an off-by-one index or a swapped upper/lower word.
- The predicted bit set only in the other pair. This catches a wrong table select.

The exact-match and broadcast rules are tried with the tables clear, so that only those rules can accept. The remaining runs cover stream timing: bubbles between bytes, surplus bytes after the sixth, a restart in the middle of an address, and a first frame sent without a start strobe after reset.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // fold one byte, LSB first, reflected polynomial
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/af_frame_tracker.sv
module af_frame_tracker #(
  parameter  int ADDR_BYTES = 6,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              beat,
  input  logic [7:0]        in_byte,
  output logic              take,
  output logic              last,
  output logic [ADDR_W-1:0] addr_full
);
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_base;
  logic [ADDR_W-9:0]   head_q;   // earlier bytes; the newest one is in_byte

  assign cnt_base  = frame_start ? '0 : cnt_q;
  assign take      = beat && (cnt_base < CNT_W'(ADDR_BYTES));
  assign last      = take && (cnt_base == CNT_W'(ADDR_BYTES - 1));
  assign addr_full = {head_q, in_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      head_q <= '0;
    end else begin
      if (take) begin
        cnt_q  <= cnt_base + CNT_W'(1);
        head_q <= {head_q[ADDR_W-17:0], in_byte};
      end else if (frame_start) begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/af_crc_engine.sv
module af_crc_engine
  import addr_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             take,
  input  logic [7:0]       in_byte,
  output logic [CRC_W-1:0] crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] seed;

  assign seed     = restart ? CRC_SEED : crc_q;
  assign crc_next = crc_fold_byte(seed, in_byte);

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= CRC_SEED;
    else if (take)    crc_q <= crc_next;
    else if (restart) crc_q <= CRC_SEED;
  end
endmodule

// File: rtl/af_hash_lookup.sv
module af_hash_lookup #(
  parameter  int HASH_W = 6,
  localparam int TBL_W  = (1 << HASH_W) / 2
) (
  input  logic [HASH_W-1:0] idx,
  input  logic              use_group,
  input  logic [TBL_W-1:0]  ind_hi,
  input  logic [TBL_W-1:0]  ind_lo,
  input  logic [TBL_W-1:0]  grp_hi,
  input  logic [TBL_W-1:0]  grp_lo,
  output logic              hit
);
  logic [2*TBL_W-1:0] ind_flat, grp_flat, sel_flat;

  // upper word carries indices TBL_W .. 2*TBL_W-1
  genvar g;
  generate
    for (g = 0; g < TBL_W; g++) begin : g_flat
      assign ind_flat[g]         = ind_lo[g];
      assign ind_flat[g + TBL_W] = ind_hi[g];
      assign grp_flat[g]         = grp_lo[g];
      assign grp_flat[g + TBL_W] = grp_hi[g];
    end
  endgenerate

  assign sel_flat = use_group ? grp_flat : ind_flat;
  assign hit      = sel_flat[idx];
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
#(
  parameter  int ADDR_BYTES = 6,
  parameter  int HASH_W     = 6,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int TBL_W      = (1 << HASH_W) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic [31:0]       exact_hi,
  input  logic [ADDR_W-33:0] exact_lo,
  input  logic [TBL_W-1:0]  ind_tbl_hi,
  input  logic [TBL_W-1:0]  ind_tbl_lo,
  input  logic [TBL_W-1:0]  grp_tbl_hi,
  input  logic [TBL_W-1:0]  grp_tbl_lo,
  input  logic              bcast_reject,
  output logic              result_valid,
  output logic              accept
);
  logic              ready_q;
  logic              take, last, hit;
  logic [ADDR_W-1:0] addr_full;
  logic [CRC_W-1:0]  crc_next;
  logic              is_exact, is_bcast, verdict;

  assign in_ready = ready_q;

  af_frame_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .beat(in_valid && ready_q), .in_byte(in_byte),
    .take(take), .last(last), .addr_full(addr_full));

  af_crc_engine u_crc (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .take(take),
    .in_byte(in_byte), .crc_next(crc_next));

  af_hash_lookup #(.HASH_W(HASH_W)) u_hash (
    .idx(crc_next[CRC_W-1 -: HASH_W]),
    .use_group(addr_full[ADDR_W-8]),
    .ind_hi(ind_tbl_hi), .ind_lo(ind_tbl_lo),
    .grp_hi(grp_tbl_hi), .grp_lo(grp_tbl_lo),
    .hit(hit));

  assign is_exact = (addr_full == {exact_hi, exact_lo});
  assign is_bcast = &addr_full;
  assign verdict  = is_exact || (is_bcast && !bcast_reject) || hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q      <= 1'b0;
      result_valid <= 1'b0;
      accept       <= 1'b0;
    end else begin
      ready_q      <= 1'b1;
      result_valid <= last;
      accept       <= last && verdict;
    end
  end
endmodule

// File: rtl/af_check.sv
module af_check #(
  parameter  int ADDR_BYTES = 6,
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_byte,
  input logic [31:0]       exact_hi,
  input logic [ADDR_W-33:0] exact_lo,
  input logic              bcast_reject,
  input logic              result_valid,
  input logic              accept
);
  int              seen;
  logic [ADDR_W-1:0] cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 0;
      cap  <= '0;
    end else if (frame_start) begin
      seen <= (in_valid && in_ready) ? 1 : 0;
      cap  <= {cap[ADDR_W-9:0], in_byte};
    end else if (in_valid && in_ready && seen < ADDR_BYTES) begin
      seen <= seen + 1;
      cap  <= {cap[ADDR_W-9:0], in_byte};
    end
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  p_accept_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> !accept);
  p_sixth_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (seen == ADDR_BYTES));
  p_exact_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && cap == {$past(exact_hi), $past(exact_lo)}) |-> accept);
  p_bcast_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && (&cap) && !$past(bcast_reject)) |-> accept);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

bind addr_filter af_check #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_ready(in_ready), .in_byte(in_byte), .exact_hi(exact_hi),
  .exact_lo(exact_lo), .bcast_reject(bcast_reject),
  .result_valid(result_valid), .accept(accept));

// File: tb/addr_filter_tb.sv
module addr_filter_tb;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, in_valid = 0, in_ready, bcast_reject = 0;
  logic [7:0]  in_byte = 0;
  logic [31:0] exact_hi = 0, ind_hi = 0, ind_lo = 0, grp_hi = 0, grp_lo = 0;
  logic [15:0] exact_lo = 0;
  logic result_valid, accept;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .exact_hi(exact_hi), .exact_lo(exact_lo),
    .ind_tbl_hi(ind_hi), .ind_tbl_lo(ind_lo), .grp_tbl_hi(grp_hi), .grp_tbl_lo(grp_lo),
    .bcast_reject(bcast_reject), .result_valid(result_valid), .accept(accept));

  // {expect, bcast_reject, use_exact, mode[1:0], address[47:0]}
  // mode 0: tables clear, 1: predicted bit in correct pair,
  //      2: all ones except predicted bit, 3: predicted bit in wrong pair only
  localparam logic [52:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b1, 2'd0, 48'h02_11_22_33_44_55},  // R4 exact
    {1'b0, 1'b0, 1'b0, 2'd0, 48'h02_11_22_33_44_56},  // R4 miss
    {1'b1, 1'b0, 1'b0, 2'd1, 48'h00_A0_C9_12_34_56},  // R1 R2 individual
    {1'b1, 1'b0, 1'b0, 2'd1, 48'h01_00_5E_00_00_FB},  // R3 group
    {1'b0, 1'b0, 1'b0, 2'd2, 48'h01_00_5E_00_00_FB},  // R2 index exact bit
    {1'b0, 1'b0, 1'b0, 2'd3, 48'h00_A0_C9_12_34_56},  // R3 wrong pair
    {1'b1, 1'b0, 1'b0, 2'd0, 48'hFF_FF_FF_FF_FF_FF},  // R5 broadcast
    {1'b0, 1'b1, 1'b0, 2'd0, 48'hFF_FF_FF_FF_FF_FF},  // R5 rejected
    {1'b1, 1'b0, 1'b0, 2'd1, 48'h33_33_00_00_00_01},  // R1 R3 group
    {1'b0, 1'b0, 1'b0, 2'd2, 48'h00_1B_21_AA_BB_CC}   // R2 R3 individual
  };

  function automatic logic [5:0] model_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0] b;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      b = a[47 - 8*k -: 8];
      for (int j = 0; j < 8; j++)
        c = ((c[0] ^ b[j]) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic setup(input logic [47:0] a, input logic [1:0] mode,
                       input logic use_ex, input logic rej);
    logic [63:0] one, mine, other;
    one = 64'd1 << model_idx(a);
    case (mode)
      2'd1:    begin mine = one;  other = 64'd0; end
      2'd2:    begin mine = ~one; other = '1;    end
      2'd3:    begin mine = 64'd0; other = one;  end
      default: begin mine = 64'd0; other = 64'd0; end
    endcase
    if (a[40]) begin {grp_hi, grp_lo} = mine;  {ind_hi, ind_lo} = other; end
    else       begin {ind_hi, ind_lo} = mine;  {grp_hi, grp_lo} = other; end
    {exact_hi, exact_lo} = use_ex ? a : 48'h0A_0B_0C_0D_0E_0F;
    bcast_reject = rej;
  endtask

  // drive six bytes; returns verdict sampled in the cycle after the sixth
  task automatic send(input logic [47:0] a, input logic sof, input logic gaps,
                      input string req, output logic got_v, output logic got_a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      frame_start = sof && (i == 0);
      in_valid = 1;
      in_byte = a[47 - 8*i -: 8];
      if (gaps && i < 5) begin
        @(negedge clk);
        frame_start = 0; in_valid = 0;
        check({req, " no early result"}, result_valid, 1'b0);
      end
    end
    @(negedge clk);
    frame_start = 0; in_valid = 0;
    got_v = result_valid; got_a = accept;
    @(negedge clk);
    check({req, " R6 pulse ends"}, result_valid, 1'b0);
    check({req, " R6 accept qualified"}, accept, 1'b0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic v, a;
    repeat (3) @(negedge clk);
    check("R10 result_valid in reset", result_valid, 1'b0);
    check("R10 accept in reset", accept, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R9 in_ready after reset", in_ready, 1'b1);

    // R10: armed after reset, no start strobe needed
    setup(48'h00_A0_C9_12_34_56, 2'd1, 1'b0, 1'b0);
    send(48'h00_A0_C9_12_34_56, 1'b0, 1'b0, "R10", v, a);
    check("R10 armed valid", v, 1'b1);
    check("R10 armed accept", a, 1'b1);

    for (int n = 0; n < 10; n++) begin
      setup(VEC[n][47:0], VEC[n][49:48], VEC[n][50], VEC[n][51]);
      send(VEC[n][47:0], 1'b1, 1'b0, "vec", v, a);
      check("R6 vector result_valid", v, 1'b1);
      check("R1 R2 R3 R4 R5 vector accept", a, VEC[n][52]);
    end

    // R9: bubbles between bytes
    setup(48'h01_00_5E_00_00_FB, 2'd1, 1'b0, 1'b0);
    send(48'h01_00_5E_00_00_FB, 1'b1, 1'b1, "R9", v, a);
    check("R9 gaps valid", v, 1'b1);
    check("R9 gaps accept", a, 1'b1);

    // R7: surplus bytes ignored
    setup(48'h00_1B_21_AA_BB_CC, 2'd1, 1'b0, 1'b0);
    send(48'h00_1B_21_AA_BB_CC, 1'b1, 1'b0, "R7", v, a);
    check("R7 first verdict", a, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); in_valid = 1; in_byte = 8'hFF;
      @(negedge clk); in_valid = 0;
      check("R7 no result from surplus byte", result_valid, 1'b0);
    end

    // R8: restart mid-address
    setup(48'h33_33_00_00_00_01, 2'd1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); frame_start = (i == 0); in_valid = 1; in_byte = 8'hFF;
    end
    send(48'h33_33_00_00_00_01, 1'b1, 1'b0, "R8", v, a);
    check("R8 restart valid", v, 1'b1);
    check("R8 restart accept", a, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule